// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block sits on the controller side of a two-wire serial bus. It frees a bus on which a target device has been left holding the data line low, for example after a transfer was cut short, after a power dip or after a reset. A single request starts the sequence. The sequencer toggles the clock line by itself, leaving the data line undriven, so that a stuck target can finish shifting out its bits. At the end of every clock-high phase it looks at the data line. When it sees the data line high, it generates a start condition, then a closing low/high clock and a data release. This leaves the bus idle and clean.

If the data line is still low after the last permitted clock pulse, the sequencer gives up. It raises a one-cycle fail flag and lets go of both lines. The lengths of the clock-low phase, the clock-high phase and the start hold are all counts of the system clock set by parameters. The defaults give 1.2 µs low, 0.6 µs high and 0.6 µs hold at 125 MHz. Both line outputs are pull-down enables for open-drain pads. A value of 1 pulls the line low.

Top module: `busclr_seq`

## Requirements
- R1: After reset, and whenever no sequence is active, scl_pull, sda_pull, busy, done and fail are all 0.
- R2: A recover_req sampled high while idle makes busy and scl_pull read 1 from the next cycle on, with sda_pull at 0.
- R3: Every clock-low phase lasts exactly LOW_CYC cycles. Every clock-high phase that is followed by another recovery pulse lasts exactly HIGH_CYC cycles.
- R4: sda_pull stays 0 throughout the recovery pulses, including every cycle in which the data line is sampled.
- R5: sda_in is sampled in the last cycle of each clock-high phase. The first pulse whose sample reads 1 is the last pulse issued, so a bus freed after K pulses sees max(K,1) pulses.
- R6: A start is made by raising sda_pull while scl_pull is 0. The clock stays released for the HIGH_CYC sample phase plus exactly HOLD_CYC further cycles before scl_pull returns to 1.
- R7: After the start, scl_pull is 1 for LOW_CYC cycles and then 0 for HIGH_CYC cycles while sda_pull stays 1. In the following cycle sda_pull drops to 0, busy drops and done is 1 for exactly one cycle.
- R8: At most MAX_PULSES (default 9) pulses are issued. If the sample of the last one reads 0, fail is 1 for one cycle, no start is made, and both pull enables are 0 with busy low.
- R9: A recover_req that arrives while busy is 1 has no effect. The pulse count and outcome of the running sequence are unchanged, and no second sequence follows it.
- R10: done and fail are never 1 in the same cycle, and busy is 0 whenever either is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| recover_req | input | 1 | Request to run one recovery sequence |
| sda_in | input | 1 | Level of the data line, synchronous to clk |
| scl_pull | output | 1 | 1 pulls the clock line low |
| sda_pull | output | 1 | 1 pulls the data line low |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse: bus freed and left idle |
| fail | output | 1 | One-cycle pulse: data line still low after the last pulse |

## Verification
The properties take sda_in to be already synchronous to clk and stable across the sampling cycle at the end of each clock-high phase. They also take the clock line to follow scl_pull without stretching by a target. The bench keeps to this with a target model, updated on the falling edge of clk, that counts clock releases and lets go of the data line only at the start of a high phase. That leaves HIGH_CYC-1 settled cycles before the sample. Requests are pulsed for a single cycle, both from idle and at a point in the middle of a sequence.

// File: rtl/busclr_pkg.sv
package busclr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_CLK_LO   = 3'd1,
    ST_CLK_HI   = 3'd2,
    ST_STA_HOLD = 3'd3,
    ST_STA_LO   = 3'd4,
    ST_STA_REL  = 3'd5
  } state_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // number of clk cycles spent in a phase
  function automatic int unsigned phase_len(input state_e s, input int unsigned lo,
                                            input int unsigned hi, input int unsigned hold);
    case (s)
      ST_CLK_LO, ST_STA_LO:  return lo;
      ST_CLK_HI, ST_STA_REL: return hi;
      ST_STA_HOLD:           return hold;
      default:               return 1;
    endcase
  endfunction

  function automatic logic scl_pulled(input state_e s);
    return (s == ST_CLK_LO) || (s == ST_STA_LO);
  endfunction

  function automatic logic sda_pulled(input state_e s);
    return (s == ST_STA_HOLD) || (s == ST_STA_LO) || (s == ST_STA_REL);
  endfunction

endpackage

// File: rtl/busclr_phase_timer.sv
module busclr_phase_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [CW-1:0] len,
  output logic          last
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else          cnt_q <= cnt_q + CW'(1);
  end

  assign last = (cnt_q == len - CW'(1));
endmodule

// File: rtl/busclr_pulse_counter.sv
module busclr_pulse_counter #(
  parameter int unsigned MAX_PULSES = 9,
  localparam int unsigned PW = $clog2(MAX_PULSES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [PW-1:0] count,
  output logic          at_max
);
  always_ff @(posedge clk) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else if (inc) count <= count + PW'(1);
  end

  assign at_max = (count == PW'(MAX_PULSES));
endmodule

// File: rtl/busclr_seq.sv
module busclr_seq
  import busclr_pkg::*;
#(
  parameter int unsigned LOW_CYC    = 150,
  parameter int unsigned HIGH_CYC   = 75,
  parameter int unsigned HOLD_CYC   = 75,
  parameter int unsigned MAX_PULSES = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic recover_req,
  input  logic sda_in,
  output logic scl_pull,
  output logic sda_pull,
  output logic busy,
  output logic done,
  output logic fail
);
  localparam int unsigned MAXLEN = max3(LOW_CYC, HIGH_CYC, HOLD_CYC);
  localparam int unsigned CW     = $clog2(MAXLEN + 1);
  localparam int unsigned PW     = $clog2(MAX_PULSES + 1);

  state_e state_q, state_d;

  // named internal events
  logic          phase_last;
  logic          advance;
  logic          start_evt;
  logic          sample_evt;
  logic          bus_free;
  logic          give_up;
  logic          pulse_inc;
  logic          at_max;
  logic [PW-1:0] pulse_count;
  logic [CW-1:0] cur_len;
  logic          done_q, fail_q;

  assign cur_len    = CW'(phase_len(state_q, LOW_CYC, HIGH_CYC, HOLD_CYC));
  assign start_evt  = (state_q == ST_IDLE) && recover_req;
  assign advance    = (state_q != ST_IDLE) && phase_last;
  assign sample_evt = (state_q == ST_CLK_HI) && phase_last;
  assign bus_free   = sample_evt && sda_in;
  assign give_up    = sample_evt && !sda_in && at_max;
  assign pulse_inc  = (state_q == ST_CLK_LO) && phase_last;

  busclr_phase_timer #(.CW(CW)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (advance || (state_q == ST_IDLE)),
    .len  (cur_len),
    .last (phase_last)
  );

  busclr_pulse_counter #(.MAX_PULSES(MAX_PULSES)) u_pulses (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start_evt),
    .inc   (pulse_inc),
    .count (pulse_count),
    .at_max(at_max)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:     if (recover_req) state_d = ST_CLK_LO;
      ST_CLK_LO:   if (phase_last)  state_d = ST_CLK_HI;
      ST_CLK_HI: begin
        if (bus_free)        state_d = ST_STA_HOLD;
        else if (give_up)    state_d = ST_IDLE;
        else if (phase_last) state_d = ST_CLK_LO;
      end
      ST_STA_HOLD: if (phase_last)  state_d = ST_STA_LO;
      ST_STA_LO:   if (phase_last)  state_d = ST_STA_REL;
      ST_STA_REL:  if (phase_last)  state_d = ST_IDLE;
      default:                      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_STA_REL) && phase_last;
      fail_q  <= give_up;
    end
  end

  assign scl_pull = scl_pulled(state_q);
  assign sda_pull = sda_pulled(state_q);
  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign fail     = fail_q;
endmodule

// File: rtl/busclr_seq_chk.sv
module busclr_seq_chk #(
  parameter int unsigned MAX_PULSES = 9,
  localparam int unsigned PW = $clog2(MAX_PULSES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          recover_req,
  input logic          sda_in,
  input logic          scl_pull,
  input logic          sda_pull,
  input logic          busy,
  input logic          done,
  input logic          fail,
  input logic [PW-1:0] pulse_count,
  input logic          sample_evt
);
  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_pull && !sda_pull));

  a_r2_req_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && recover_req) |=> (busy && scl_pull && !sda_pull));

  a_r4_quiet_sample: assert property (@(posedge clk) disable iff (!rst_n)
    sample_evt |-> !sda_pull);

  a_r5_start_after_free: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> $past(sda_in));

  a_r6_start_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_pull);

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_pulse_cap: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_count <= PW'(MAX_PULSES));

  a_r8_fail_releases: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (!scl_pull && !sda_pull && !busy));

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail) && !((done || fail) && busy));
endmodule

bind busclr_seq busclr_seq_chk #(.MAX_PULSES(MAX_PULSES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .recover_req(recover_req),
  .sda_in     (sda_in),
  .scl_pull   (scl_pull),
  .sda_pull   (sda_pull),
  .busy       (busy),
  .done       (done),
  .fail       (fail),
  .pulse_count(pulse_count),
  .sample_evt (sample_evt)
);

// File: tb/busclr_seq_bench.sv
module busclr_seq_bench;
  localparam int LOW  = 150;
  localparam int HIGH = 75;
  localparam int HOLD = 75;
  localparam int MAXP = 9;
  localparam int NCASE = 8;

  // per case: {target hold pulses K, inject mid-sequence request}
  localparam int CASES [NCASE][2] = '{
    '{0, 0}, '{1, 0}, '{3, 0}, '{5, 1}, '{9, 0}, '{10, 0}, '{2, 0}, '{12, 1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic recover_req = 1'b0;
  logic sda_in = 1'b1;
  logic scl_pull, sda_pull, busy, done, fail;

  int tests = 0;
  int failed = 0;

  always #4 clk = ~clk;

  busclr_seq #(.LOW_CYC(LOW), .HIGH_CYC(HIGH), .HOLD_CYC(HOLD), .MAX_PULSES(MAXP))
    u_busclr_seq (
      .clk(clk), .rst_n(rst_n), .recover_req(recover_req), .sda_in(sda_in),
      .scl_pull(scl_pull), .sda_pull(sda_pull), .busy(busy), .done(done), .fail(fail));

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    tests++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic run_case(input int k, input bit inject);
    int  exp_p;
    bit  exp_fail;
    int  rises, run, hold_run;
    bit  prev_scl, prev_sda, sta_seen, started, injected, finished, bad_r4, bad_r10;
    int  low_bad, high_bad;
    exp_fail = (k > MAXP);
    exp_p    = exp_fail ? MAXP : ((k < 1) ? 1 : k);
    rises = 0; run = 0; hold_run = 0; prev_scl = 0; prev_sda = 0;
    sta_seen = 0; started = 0; injected = 0; finished = 0; bad_r4 = 0; bad_r10 = 0;
    low_bad = 0; high_bad = 0;
    @(negedge clk);
    recover_req = 1'b1;
    sda_in = (k > 0) ? 1'b0 : 1'b1;
    @(negedge clk);
    recover_req = 1'b0;
    chk(busy && scl_pull && !sda_pull, "R2 start", {busy, scl_pull, sda_pull}, 3'b110);
    prev_scl = 1; run = 1; started = 1;
    for (int n = 0; n < 10000 && !finished; n++) begin
      @(negedge clk);
      recover_req = 1'b0;
      if (inject && !injected && rises == 2) begin
        recover_req = 1'b1;
        injected = 1;
      end
      if ((done && fail) || ((done || fail) && busy)) bad_r10 = 1;
      if (sda_pull && scl_pull && !sta_seen) bad_r4 = 1;
      if (sda_pull && !prev_sda) begin
        sta_seen = 1;
        chk(!scl_pull, "R6 start with clock released", scl_pull, 0);
        chk(rises == exp_p, "R5 pulses before start", rises, exp_p);
      end
      if (scl_pull == prev_scl) run++;
      else begin
        if (prev_scl) begin
          if (run != LOW) low_bad++;
          if (!sta_seen) rises++;
        end else if (sta_seen) begin
          chk(run == HIGH + HOLD, "R6 sample+hold length", run, HIGH + HOLD);
        end else if (run != HIGH) high_bad++;
        run = 1;
      end
      prev_scl = scl_pull;
      prev_sda = sda_pull;
      sda_in = !(((rises < k) && !sta_seen) || sda_pull);
      if (done) begin
        finished = 1;
        chk(!exp_fail, "R7 done outcome", 1, 0 + !exp_fail);
        chk(!sda_pull && !scl_pull && !busy, "R7 release at done",
            {sda_pull, scl_pull, busy}, 0);
        chk(run == HIGH + 1, "R7 final release length", run - 1, HIGH);
      end
      if (fail) begin
        finished = 1;
        chk(exp_fail, "R8 fail outcome", 1, 0 + exp_fail);
        chk(rises == MAXP && !sta_seen, "R8 pulse cap", rises, MAXP);
        chk(!sda_pull && !scl_pull && !busy, "R8 release at fail",
            {sda_pull, scl_pull, busy}, 0);
      end
    end
    chk(finished, "R7/R8 sequence ends", finished, 1);
    chk(low_bad == 0, "R3 low width", low_bad, 0);
    chk(high_bad == 0, "R3 high width", high_bad, 0);
    chk(!bad_r4, "R4 data undriven while clocking", bad_r4, 0);
    chk(!bad_r10, "R10 done/fail exclusive", bad_r10, 0);
    @(negedge clk);
    chk(!done && !fail, "R7 one-cycle flag", {done, fail}, 0);
    if (inject) begin
      repeat (10) @(negedge clk);
      chk(!busy && !scl_pull, "R9 request during busy ignored", busy, 0);
    end
    sda_in = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failed++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({scl_pull, sda_pull, busy, done, fail} == 5'b0, "R1 reset state",
        {scl_pull, sda_pull, busy, done, fail}, 0);
    for (int i = 0; i < NCASE; i++) run_case(CASES[i][0], CASES[i][1] != 0);
    // R1 idle with no request over a long window
    repeat (20) @(negedge clk);
    chk({scl_pull, sda_pull, busy, done, fail} == 5'b0, "R1 idle stays released",
        {scl_pull, sda_pull, busy, done, fail}, 0);
    // reset in mid-sequence releases everything
    @(negedge clk); recover_req = 1'b1; sda_in = 1'b0;
    @(negedge clk); recover_req = 1'b0;
    repeat (40) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1; sda_in = 1'b1;
    @(negedge clk);
    chk({scl_pull, sda_pull, busy} == 3'b0, "R1 reset aborts sequence",
        {scl_pull, sda_pull, busy}, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule